// File: doc/BRIEF.md
# Predicated Word Gather-Load Sequencer

This block carries out one gather load of 32-bit words into a vector destination. A start pulse hands it a 64-bit scalar base, a vector of 32-bit indices (one per 32-bit lane), a lane enable mask, and two control bits. One control bit selects sign or zero extension of each index. The other selects whether the extended index is scaled by four. The block visits the enabled lanes from lane 0 upward. For each one it issues a single word read on a valid/ready request port, and it waits for that read's response before it moves on.

Lanes whose mask bit is clear cause no memory traffic and read back as zero. The assembled vector is held internally. It is handed to the destination with a single write-enable pulse, together with a done pulse. A flag marks the base as coming from the stack pointer. When that flag is set and at least one lane is enabled, a base that is not 16-byte aligned aborts the operation before any read. An error response from memory also aborts it. Both aborts suppress the commit. The block has no condition-flag outputs.

Top module: `vgather_seq`

## Requirements
- R1: The vector holds VL/32 lanes (8 by default). Enabled lanes are read in ascending lane order, with exactly one request per enabled lane.
- R2: The request address of a lane is the base plus the lane's extended and scaled index, taken modulo 2^64.
- R3: With idx_signed_i=1 the 32-bit index is sign-extended to 64 bits. With idx_signed_i=0 it is zero-extended.
- R4: With idx_scale4_i=1 the extended index is multiplied by 4. With idx_scale4_i=0 it is used as is.
- R5: A lane whose bit in lane_en_i is clear (bit i controls lane i) issues no request, and bits [32*i+31:32*i] of the committed vector are zero.
- R6: The response word of lane i lands unchanged in bits [32*i+31:32*i] of the committed vector.
- R7: If base_is_sp_i=1, at least one lane is enabled and base_i[3:0]!=0, then fault_align_o pulses for one cycle in the cycle after the start edge. No request and no commit follow. If no lane is enabled, no alignment fault is raised.
- R8: A response with mem_rsp_err_i=1 aborts the operation. fault_mem_o pulses in the cycle after that response, and no further request and no commit follow.
- R9: A commit raises wr_en_o and done_o together for exactly one cycle, with the full result on wr_data_o. The block is idle in the next cycle.
- R10: With no lane enabled, the commit of an all-zero vector appears in the cycle after the start edge, with no request.
- R11: start_i is ignored while busy_o is high.
- R12: A request holds its address stable until it is accepted. No new request is raised while a response is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an operation (taken only when idle) |
| base_i | input | 64 | Scalar base address |
| base_is_sp_i | input | 1 | Base comes from the stack pointer; enables the alignment check |
| idx_i | input | VL | Per-lane 32-bit indices, lane i in bits [32*i+31:32*i] |
| lane_en_i | input | VL/32 | Lane enable mask |
| idx_signed_i | input | 1 | 1: sign-extend indices, 0: zero-extend |
| idx_scale4_i | input | 1 | 1: multiply the index by 4 |
| busy_o | output | 1 | Operation in progress |
| mem_req_valid_o | output | 1 | Read request valid |
| mem_req_ready_i | input | 1 | Read request accepted |
| mem_req_addr_o | output | 64 | Read address |
| mem_rsp_valid_i | input | 1 | Read response valid |
| mem_rsp_data_i | input | 32 | Read response word |
| mem_rsp_err_i | input | 1 | Read response carries an error |
| wr_en_o | output | 1 | Destination write enable (one cycle) |
| wr_data_o | output | VL | Assembled result vector |
| done_o | output | 1 | Operation committed |
| fault_align_o | output | 1 | Stack-pointer base misaligned (one cycle) |
| fault_mem_o | output | 1 | Memory error abort (one cycle) |

## Verification
Every output is decoded from a state register, so each result is due exactly one clock edge after its cause. The first request is due after the start edge, the next request or the commit after the accepting response edge, fault_align_o after the start edge, and fault_mem_o after the failing response edge. The bench changes inputs on the falling edge and samples in the falling-edge window that follows the edge that should produce the result. It checks there and never waits for an event, so a result that comes one cycle early or late is reported as a failure. Request stalls and response delays are varied, so the bench also confirms that the address holds still and that nothing new is issued while a read is outstanding.

// File: rtl/vg_pkg.sv
package vg_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT,
    ST_COMMIT,
    ST_FALIGN,
    ST_FMEM
  } vg_state_e;

  // Lane address: base + extend(index) scaled by 1 or 4, modulo 2^64
  function automatic logic [63:0] vg_lane_addr(input logic [63:0] base,
                                               input logic [31:0] idx,
                                               input logic        sgn,
                                               input logic        scl4);
    logic [63:0] ext;
    ext = sgn ? {{32{idx[31]}}, idx} : {32'd0, idx};
    return base + (scl4 ? {ext[61:0], 2'b00} : ext);
  endfunction

  // Stack-pointer base must be 16-byte aligned when any lane is enabled
  function automatic logic vg_misaligned(input logic [63:0] base,
                                         input logic        is_sp,
                                         input logic        any_en);
    return is_sp && any_en && (base[3:0] != 4'd0);
  endfunction

endpackage

// File: rtl/vg_lane_pick.sv
module vg_lane_pick #(
  parameter int LANES = 8,
  parameter int LW    = 3
) (
  input  logic [LANES-1:0] mask_i,
  input  logic [LW:0]      from_i,
  output logic             found_o,
  output logic [LW-1:0]    lane_o
);
  // Lowest enabled lane at or above from_i
  always_comb begin
    found_o = 1'b0;
    lane_o  = '0;
    for (int k = LANES - 1; k >= 0; k--) begin
      if (mask_i[k] && ((LW+1)'(k) >= from_i)) begin
        found_o = 1'b1;
        lane_o  = LW'(k);
      end
    end
  end
endmodule

// File: rtl/vg_addr_gen.sv
module vg_addr_gen #(
  parameter int VL = 256,
  parameter int LW = 3
) (
  input  logic [63:0]   base_i,
  input  logic [VL-1:0] idx_vec_i,
  input  logic [LW-1:0] lane_i,
  input  logic          sgn_i,
  input  logic          scl4_i,
  output logic [63:0]   addr_o
);
  import vg_pkg::*;
  logic [31:0] lane_idx;
  assign lane_idx = idx_vec_i[32*int'(lane_i) +: 32];
  assign addr_o   = vg_lane_addr(base_i, lane_idx, sgn_i, scl4_i);
endmodule

// File: rtl/vg_result_buf.sv
module vg_result_buf #(
  parameter int LANES = 8,
  parameter int LW    = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               we_i,
  input  logic [LW-1:0]      lane_i,
  input  logic [31:0]        data_i,
  output logic [32*LANES-1:0] vec_o
);
  logic [31:0] word_q [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            word_q[g] <= '0;
      else if (clr_i)                        word_q[g] <= '0;
      else if (we_i && (lane_i == LW'(g)))   word_q[g] <= data_i;
    end
    assign vec_o[32*g +: 32] = word_q[g];
  end

  // R5: a fresh operation starts from an all-zero vector
  a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (vec_o == '0));
endmodule

// File: rtl/vgather_seq.sv
module vgather_seq #(
  parameter int VL = 256
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [63:0]        base_i,
  input  logic               base_is_sp_i,
  input  logic [VL-1:0]      idx_i,
  input  logic [VL/32-1:0]   lane_en_i,
  input  logic               idx_signed_i,
  input  logic               idx_scale4_i,
  output logic               busy_o,
  output logic               mem_req_valid_o,
  input  logic               mem_req_ready_i,
  output logic [63:0]        mem_req_addr_o,
  input  logic               mem_rsp_valid_i,
  input  logic [31:0]        mem_rsp_data_i,
  input  logic               mem_rsp_err_i,
  output logic               wr_en_o,
  output logic [VL-1:0]      wr_data_o,
  output logic               done_o,
  output logic               fault_align_o,
  output logic               fault_mem_o
);
  import vg_pkg::*;

  localparam int LANES = VL / 32;
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1;

  vg_state_e          state_q, state_d;
  logic [63:0]        base_q;
  logic [VL-1:0]      idx_q;
  logic [LANES-1:0]   en_q;
  logic               sgn_q, scl_q;
  logic [LW-1:0]      lane_q, lane_d;

  // Named internal events
  logic               start_take, misal, req_fire, rsp_take, rsp_ok, rsp_bad;
  logic               first_found, nxt_found;
  logic [LW-1:0]      first_lane, nxt_lane;

  vg_lane_pick #(.LANES(LANES), .LW(LW)) u_first (
    .mask_i (lane_en_i),
    .from_i ('0),
    .found_o(first_found),
    .lane_o (first_lane)
  );

  vg_lane_pick #(.LANES(LANES), .LW(LW)) u_next (
    .mask_i (en_q),
    .from_i ({1'b0, lane_q} + (LW+1)'(1)),
    .found_o(nxt_found),
    .lane_o (nxt_lane)
  );

  vg_addr_gen #(.VL(VL), .LW(LW)) u_addr (
    .base_i   (base_q),
    .idx_vec_i(idx_q),
    .lane_i   (lane_q),
    .sgn_i    (sgn_q),
    .scl4_i   (scl_q),
    .addr_o   (mem_req_addr_o)
  );

  vg_result_buf #(.LANES(LANES), .LW(LW)) u_buf (
    .clk   (clk),
    .rst_n (rst_n),
    .clr_i (start_take),
    .we_i  (rsp_ok),
    .lane_i(lane_q),
    .data_i(mem_rsp_data_i),
    .vec_o (wr_data_o)
  );

  assign start_take = start_i && (state_q == ST_IDLE);
  assign misal      = vg_misaligned(base_i, base_is_sp_i, first_found);
  assign req_fire   = mem_req_valid_o && mem_req_ready_i;
  assign rsp_take   = (state_q == ST_WAIT) && mem_rsp_valid_i;
  assign rsp_ok     = rsp_take && !mem_rsp_err_i;
  assign rsp_bad    = rsp_take && mem_rsp_err_i;

  always_comb begin
    state_d = state_q;
    lane_d  = lane_q;
    unique case (state_q)
      ST_IDLE: begin
        if (start_take) begin
          if (misal)            state_d = ST_FALIGN;
          else if (first_found) begin
            state_d = ST_REQ;
            lane_d  = first_lane;
          end
          else                  state_d = ST_COMMIT;
        end
      end
      ST_REQ:  if (req_fire) state_d = ST_WAIT;
      ST_WAIT: begin
        if (rsp_bad)          state_d = ST_FMEM;
        else if (rsp_ok) begin
          if (nxt_found) begin
            state_d = ST_REQ;
            lane_d  = nxt_lane;
          end
          else state_d = ST_COMMIT;
        end
      end
      ST_COMMIT, ST_FALIGN, ST_FMEM: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      lane_q  <= '0;
      base_q  <= '0;
      idx_q   <= '0;
      en_q    <= '0;
      sgn_q   <= 1'b0;
      scl_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      lane_q  <= lane_d;
      if (start_take) begin
        base_q <= base_i;
        idx_q  <= idx_i;
        en_q   <= lane_en_i;
        sgn_q  <= idx_signed_i;
        scl_q  <= idx_scale4_i;
      end
    end
  end

  assign busy_o          = (state_q != ST_IDLE);
  assign mem_req_valid_o = (state_q == ST_REQ);
  assign wr_en_o         = (state_q == ST_COMMIT);
  assign done_o          = (state_q == ST_COMMIT);
  assign fault_align_o   = (state_q == ST_FALIGN);
  assign fault_mem_o     = (state_q == ST_FMEM);

  // R5: only enabled lanes are ever requested
  a_r5_req_lane_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid_o |-> en_q[lane_q]);

  // R12: a stalled request keeps its address
  a_r12_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid_o && !mem_req_ready_i) |=> (mem_req_valid_o && $stable(mem_req_addr_o)));

  // R12: accepted request leaves nothing new on the port in the next cycle
  a_r12_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !mem_req_valid_o);

  // R1: lanes advance upward
  a_r1_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_ok && nxt_found) |=> (lane_q > $past(lane_q)));

  // R9: commit is a single-cycle pulse followed by idle
  a_r9_commit_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en_o |=> (!wr_en_o && !busy_o));

  // R7: alignment fault only follows a misaligned stack-pointer start with enabled lanes
  a_r7_align_cause: assert property (@(posedge clk) disable iff (!rst_n)
    fault_align_o |-> $past(start_i && base_is_sp_i && (base_i[3:0] != 4'd0) && (|lane_en_i)));

  // R8: after a memory error neither commit nor new request
  a_r8_abort_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    fault_mem_o |=> (!wr_en_o && !mem_req_valid_o));

  // R11: configuration does not change while busy
  a_r11_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && $past(busy_o)) |-> $stable(en_q));

endmodule

// File: tb/sim_vgather_seq.sv
module sim_vgather_seq;
  localparam int CLK_PERIOD = 10;
  localparam int VL    = 256;
  localparam int LANES = VL / 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [63:0] base_i = '0;
  logic base_is_sp_i = 1'b0;
  logic [VL-1:0] idx_i = '0;
  logic [LANES-1:0] lane_en_i = '0;
  logic idx_signed_i = 1'b0, idx_scale4_i = 1'b0;
  logic busy_o, mem_req_valid_o, mem_req_ready_i = 1'b0;
  logic [63:0] mem_req_addr_o;
  logic mem_rsp_valid_i = 1'b0, mem_rsp_err_i = 1'b0;
  logic [31:0] mem_rsp_data_i = '0;
  logic wr_en_o, done_o, fault_align_o, fault_mem_o;
  logic [VL-1:0] wr_data_o;

  int n_checks = 0;
  int n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vgather_seq #(.VL(VL)) u0 (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .base_is_sp_i(base_is_sp_i), .idx_i(idx_i), .lane_en_i(lane_en_i),
    .idx_signed_i(idx_signed_i), .idx_scale4_i(idx_scale4_i), .busy_o(busy_o),
    .mem_req_valid_o(mem_req_valid_o), .mem_req_ready_i(mem_req_ready_i),
    .mem_req_addr_o(mem_req_addr_o), .mem_rsp_valid_i(mem_rsp_valid_i),
    .mem_rsp_data_i(mem_rsp_data_i), .mem_rsp_err_i(mem_rsp_err_i),
    .wr_en_o(wr_en_o), .wr_data_o(wr_data_o), .done_o(done_o),
    .fault_align_o(fault_align_o), .fault_mem_o(fault_mem_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Expected lane address, restated with integer arithmetic
  function automatic logic [63:0] exp_addr(input logic [63:0] b, input logic [31:0] ix,
                                           input logic sg, input logic sc);
    logic [63:0] e;
    if (sg) e = 64'($signed(ix));
    else    e = 64'(ix);
    return b + (sc ? e * 64'd4 : e);
  endfunction

  function automatic logic [31:0] mem_word(input logic [63:0] a);
    return a[31:0] ^ {a[47:32], a[63:48]} ^ 32'h5A5A_C3C3;
  endfunction

  // One operation: stall = cycles ready held low, rdly = response delay,
  // err_at = ordinal of the failing response (-1 none), poke = restart attempt while busy
  task automatic run_op(input logic [63:0] b, input logic sp, input logic [VL-1:0] ix,
                        input logic [LANES-1:0] en, input logic sg, input logic sc,
                        input int stall, input int rdly, input int err_at, input bit poke);
    logic [VL-1:0] expv;
    logic [63:0] a;
    int n;
    expv = '0;
    n = 0;
    @(negedge clk);
    base_i = b; base_is_sp_i = sp; idx_i = ix; lane_en_i = en;
    idx_signed_i = sg; idx_scale4_i = sc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int k = 0; k < LANES; k++) begin
      if (en[k]) begin
        a = exp_addr(b, ix[32*k +: 32], sg, sc);
        chk(mem_req_valid_o && (mem_req_addr_o == a), "R2 R3 R4 R1 request address",
            {mem_req_valid_o, mem_req_addr_o}, {1'b1, a});
        if (poke && n == 0) begin
          start_i = 1'b1; base_i = ~b; lane_en_i = ~en; idx_signed_i = ~sg;
          @(negedge clk);
          start_i = 1'b0;
          chk(mem_req_valid_o && (mem_req_addr_o == a), "R11 restart while busy",
              mem_req_addr_o, a);
        end
        for (int s = 0; s < stall; s++) begin
          @(negedge clk);
          chk(mem_req_valid_o && (mem_req_addr_o == a), "R12 stalled request held",
              mem_req_addr_o, a);
        end
        mem_req_ready_i = 1'b1;
        @(negedge clk);
        mem_req_ready_i = 1'b0;
        chk(!mem_req_valid_o, "R12 no request while outstanding", mem_req_valid_o, 0);
        for (int d = 0; d < rdly; d++) begin
          @(negedge clk);
          chk(!mem_req_valid_o, "R12 no request while outstanding", mem_req_valid_o, 0);
        end
        mem_rsp_valid_i = 1'b1;
        mem_rsp_data_i  = mem_word(a);
        mem_rsp_err_i   = (n == err_at);
        @(negedge clk);
        mem_rsp_valid_i = 1'b0;
        mem_rsp_err_i   = 1'b0;
        if (n == err_at) begin
          chk(fault_mem_o && !wr_en_o && !mem_req_valid_o, "R8 memory error abort",
              {fault_mem_o, wr_en_o, mem_req_valid_o}, 3'b100);
          @(negedge clk);
          chk(!busy_o && !wr_en_o && !mem_req_valid_o && !fault_mem_o, "R8 no commit after error",
              {busy_o, wr_en_o, mem_req_valid_o, fault_mem_o}, 4'b0000);
          return;
        end
        expv[32*k +: 32] = mem_word(a);
        n++;
      end
    end
    chk(wr_en_o && done_o && !mem_req_valid_o && !fault_align_o && (wr_data_o == expv),
        (en == '0) ? "R10 empty mask commit" : "R9 R5 R6 R7 commit result", wr_data_o, expv);
    @(negedge clk);
    chk(!wr_en_o && !done_o && !busy_o, "R9 single-cycle commit",
        {wr_en_o, done_o, busy_o}, 3'b000);
  endtask

  initial begin
    repeat (CLK_PERIOD * 150000) #1;
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [VL-1:0] ix;
    logic [63:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !mem_req_valid_o && !wr_en_o && !done_o && !fault_align_o && !fault_mem_o &&
        (wr_data_o == '0), "reset state", {busy_o, mem_req_valid_o, wr_en_o}, 0);

    // Exhaustive sweep over every lane mask
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < LANES; k++)
        ix[32*k +: 32] = 32'(p * 257 + k * 64) ^ ((k % 2 == 1) ? 32'hFFFF_FF00 : 32'h0) ^
                         ((p % 32 >= 16) ? 32'h8000_0000 : 32'h0);
      b = ((p % 16) >= 8) ? 64'hFFFF_FFFF_FFFF_FF00 : 64'h0000_1234_0000_0000 + 64'(p) * 64'h1_0010;
      run_op(b, (p % 8) >= 4, ix, LANES'(p), ((p % 2) ^ ((p / 32) % 2)) == 1,
             ((p / 2) % 2) == 1, p % 3, (p / 4) % 3, -1, (p % 37) == 5);
    end

    // R7: misaligned stack-pointer base with enabled lanes
    @(negedge clk);
    base_i = 64'h0000_0000_0000_1008; base_is_sp_i = 1'b1; lane_en_i = 8'h24; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    chk(fault_align_o && !mem_req_valid_o && !wr_en_o, "R7 alignment fault",
        {fault_align_o, mem_req_valid_o, wr_en_o}, 3'b100);
    @(negedge clk);
    chk(!busy_o && !fault_align_o && !wr_en_o && !mem_req_valid_o, "R7 no traffic after fault",
        {busy_o, fault_align_o, wr_en_o, mem_req_valid_o}, 4'b0000);

    // R7/R10: misaligned stack-pointer base but nothing enabled commits zeros
    run_op(64'h0000_0000_0000_0004, 1'b1, ix, 8'h00, 1'b0, 1'b0, 0, 0, -1, 1'b0);
    // R7: non-stack base may be misaligned
    run_op(64'h0000_0000_0000_0007, 1'b0, ix, 8'h81, 1'b1, 1'b1, 1, 0, -1, 1'b0);

    // R8: errors on first, middle and last response
    run_op(64'h0000_0000_0010_0000, 1'b0, ix, 8'h4A, 1'b0, 1'b1, 0, 1, 0, 1'b0);
    run_op(64'h0000_0000_0010_0000, 1'b0, ix, 8'h4A, 1'b0, 1'b1, 1, 0, 1, 1'b0);
    run_op(64'h0000_0000_0010_0000, 1'b0, ix, 8'h4A, 1'b1, 1'b0, 0, 2, 2, 1'b0);
    // R5 R6: clean operation after an abort starts from zeros
    run_op(64'h0000_0000_0020_0000, 1'b0, ix, 8'h10, 1'b0, 1'b0, 0, 0, -1, 1'b1);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule